// File: doc/BRIEF.md
# Trimmed-Mean Sample Averaging Filter

This block sits behind a 12-bit successive-approximation converter. It reduces a short burst of conversions of one channel to a single code that resists noise. A start strobe opens a burst and clears any partial one. A length select chosen with the strobe sets the burst to six or ten samples. While the burst runs, the filter keeps a running sum, the smallest sample and the largest sample.

When the last sample of the burst arrives, exactly one smallest and one largest sample are taken out of the sum. The remaining four or eight samples are averaged by a right shift, with truncation. One clock later the result appears with a one-cycle valid strobe. It is given both as a 12-bit code and as a 16-bit word with the code in the upper bits, which is the form a register file presents.

Sample strobes that arrive before the first start, or after the burst is complete, are dropped until the next start strobe.

Top module: `trim_mean_filter`

## Requirements
- R1: With the length select at 0 when the start strobe is taken, the burst holds exactly six accepted samples. The result valid is high in the cycle after the clock edge that accepts the sixth sample.
- R2: With the length select at 1 when the start strobe is taken, the burst holds exactly ten accepted samples. The result valid follows the tenth accepted sample in the same way.
- R3: For a six-sample burst, the result is (sum − min − max) shifted right by 2, truncated. Samples and result are straight-binary codes from 000h to FFFh.
- R4: For a ten-sample burst, the result is (sum − min − max) shifted right by 3, truncated toward zero.
- R5: When several samples share the minimum or maximum value, only one instance of each is removed.
- R6: The 16-bit result word equals the 12-bit result in bits 15:4, with bits 3:0 zero.
- R7: Sample strobes after the burst's final sample produce no result valid and leave the result unchanged until the next start strobe.
- R8: A start strobe during a burst discards the samples taken so far. A start strobe cycle accepts no sample.
- R9: After reset the result valid is low and the result is zero. Sample strobes before the first start strobe are ignored.
- R10: The result valid is high for exactly one cycle per completed burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start/clear strobe for a new burst |
| long_sel_i | input | 1 | Burst length select, taken with start_i: 0 = six samples, 1 = ten samples |
| smp_valid_i | input | 1 | Sample strobe |
| smp_data_i | input | 12 | Sample code |
| res_valid_o | output | 1 | One-cycle result strobe |
| res_data_o | output | 12 | Trimmed mean, held until the next result |
| res_word_o | output | 16 | Trimmed mean left-justified, low four bits zero |

## Verification
The result of a burst is due exactly one clock after the edge that accepts its final sample, and it must never come earlier or later. The driver checks the valid strobe at the falling edge just after that accepting edge. The scoreboard monitor, which also samples at falling edges, compares code and word against the model's queued value and treats any strobe with an empty queue as a failure. Extra strobes after a burst, a restart in mid-burst and strobes before the first start are each followed by falling-edge checks that no strobe appeared and that the held result did not move.

// File: rtl/trim_filter_pkg.sv
package trim_filter_pkg;

   typedef enum logic {
      LEN_SHORT = 1'b0,
      LEN_LONG  = 1'b1
   } burst_len_e;

   function automatic bit is_pow2(input int unsigned v);
      return (v != 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/trim_burst_counter.sv
module trim_burst_counter
   import trim_filter_pkg::*;
#(
   parameter int SHORT_CNT = 6,
   parameter int LONG_CNT  = 10,
   parameter int CNT_W     = $clog2(LONG_CNT + 1)
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start_i,
   input  burst_len_e len_i,
   input  logic       valid_i,
   output logic       accept_o,
   output logic       first_o,
   output logic       last_o,
   output burst_len_e len_o
);

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] tgt;
   logic             armed_q;
   burst_len_e       len_q;

   assign tgt      = (len_q == LEN_LONG) ? CNT_W'(LONG_CNT) : CNT_W'(SHORT_CNT);
   assign accept_o = armed_q & valid_i & ~start_i;
   assign first_o  = (cnt_q == '0);
   assign last_o   = accept_o & (cnt_q == tgt - CNT_W'(1));
   assign len_o    = len_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         armed_q <= 1'b0;
         len_q   <= LEN_SHORT;
      end else if (start_i) begin
         cnt_q   <= '0;
         armed_q <= 1'b1;
         len_q   <= len_i;
      end else if (accept_o) begin
         cnt_q   <= cnt_q + CNT_W'(1);
         if (last_o) armed_q <= 1'b0;
      end
   end

   assert_cnt_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= tgt);

   assert_idle_after_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!armed_q && !start_i) |=> $stable(cnt_q));

   assert_len_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (armed_q && !start_i) |=> $stable(len_q));

endmodule

// File: rtl/trim_extreme_tracker.sv
module trim_extreme_tracker #(
   parameter int DATA_W = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              accept_i,
   input  logic              first_i,
   input  logic [DATA_W-1:0] data_i,
   output logic [DATA_W-1:0] lo_nxt_o,
   output logic [DATA_W-1:0] hi_nxt_o,
   output logic [DATA_W-1:0] lo_q_o,
   output logic [DATA_W-1:0] hi_q_o
);

   logic [DATA_W-1:0] lo_q, hi_q;

   always_comb begin
      if (first_i) begin
         lo_nxt_o = data_i;
         hi_nxt_o = data_i;
      end else begin
         lo_nxt_o = (data_i < lo_q) ? data_i : lo_q;
         hi_nxt_o = (data_i > hi_q) ? data_i : hi_q;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lo_q <= '0;
         hi_q <= '0;
      end else if (accept_i) begin
         lo_q <= lo_nxt_o;
         hi_q <= hi_nxt_o;
      end
   end

   assign lo_q_o = lo_q;
   assign hi_q_o = hi_q;

   assert_lo_le_hi_R5: assert property (@(posedge clk) disable iff (!rst_n)
      lo_q <= hi_q);

endmodule

// File: rtl/trim_accumulator.sv
module trim_accumulator #(
   parameter int DATA_W = 12,
   parameter int ACC_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear_i,
   input  logic              accept_i,
   input  logic [DATA_W-1:0] data_i,
   output logic [ACC_W-1:0]  sum_nxt_o
);

   logic [ACC_W-1:0] sum_q;

   assign sum_nxt_o = sum_q + ACC_W'(data_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        sum_q <= '0;
      else if (clear_i)  sum_q <= '0;
      else if (accept_i) sum_q <= sum_nxt_o;
   end

   assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (accept_i && !clear_i) |=> (sum_q >= $past(sum_q)));

endmodule

// File: rtl/trim_result_stage.sv
module trim_result_stage
   import trim_filter_pkg::*;
#(
   parameter int DATA_W   = 12,
   parameter int ACC_W    = 16,
   parameter int SH_SHORT = 2,
   parameter int SH_LONG  = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fire_i,
   input  burst_len_e        len_i,
   input  logic [ACC_W-1:0]  sum_i,
   input  logic [DATA_W-1:0] lo_i,
   input  logic [DATA_W-1:0] hi_i,
   output logic              valid_o,
   output logic [DATA_W-1:0] data_o
);

   logic [ACC_W-1:0] trimmed;
   logic [ACC_W-1:0] shifted;

   assign trimmed = sum_i - ACC_W'(lo_i) - ACC_W'(hi_i);
   assign shifted = (len_i == LEN_LONG) ? (trimmed >> SH_LONG) : (trimmed >> SH_SHORT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_o <= 1'b0;
         data_o  <= '0;
      end else begin
         valid_o <= fire_i;
         if (fire_i) data_o <= shifted[DATA_W-1:0];
      end
   end

   assert_one_cycle_R10: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |=> !valid_o);

   assert_fits_code_R4: assert property (@(posedge clk) disable iff (!rst_n)
      fire_i |-> (shifted[ACC_W-1:DATA_W] == '0));

endmodule

// File: rtl/trim_mean_filter.sv
module trim_mean_filter
   import trim_filter_pkg::*;
#(
   parameter int DATA_W    = 12,
   parameter int OUT_W     = 16,
   parameter int SHORT_CNT = 6,
   parameter int LONG_CNT  = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              long_sel_i,
   input  logic              smp_valid_i,
   input  logic [DATA_W-1:0] smp_data_i,
   output logic              res_valid_o,
   output logic [DATA_W-1:0] res_data_o,
   output logic [OUT_W-1:0]  res_word_o
);

   localparam int CNT_W      = $clog2(LONG_CNT + 1);
   localparam int ACC_W      = DATA_W + $clog2(LONG_CNT);
   localparam int KEEP_SHORT = SHORT_CNT - 2;
   localparam int KEEP_LONG  = LONG_CNT - 2;
   localparam int SH_SHORT   = $clog2(KEEP_SHORT);
   localparam int SH_LONG    = $clog2(KEEP_LONG);
   localparam int PAD_W      = OUT_W - DATA_W;

   generate
      if (SHORT_CNT < 3 || LONG_CNT <= SHORT_CNT) begin : g_bad_counts
         $error("burst lengths must satisfy 3 <= SHORT_CNT < LONG_CNT");
      end
      if (!is_pow2(KEEP_SHORT) || !is_pow2(KEEP_LONG)) begin : g_bad_keep
         $error("trimmed sample counts must be powers of two");
      end
      if (OUT_W < DATA_W) begin : g_bad_out
         $error("OUT_W must be at least DATA_W");
      end
   endgenerate

   burst_len_e        len_req, len_cur;
   logic              accept, first, last;
   logic [DATA_W-1:0] lo_nxt, hi_nxt, lo_q, hi_q;
   logic [ACC_W-1:0]  sum_nxt;

   assign len_req = long_sel_i ? LEN_LONG : LEN_SHORT;

   trim_burst_counter #(
      .SHORT_CNT (SHORT_CNT),
      .LONG_CNT  (LONG_CNT),
      .CNT_W     (CNT_W)
   ) u_count (
      .clk      (clk),
      .rst_n    (rst_n),
      .start_i  (start_i),
      .len_i    (len_req),
      .valid_i  (smp_valid_i),
      .accept_o (accept),
      .first_o  (first),
      .last_o   (last),
      .len_o    (len_cur)
   );

   trim_extreme_tracker #(.DATA_W(DATA_W)) u_ext (
      .clk      (clk),
      .rst_n    (rst_n),
      .accept_i (accept),
      .first_i  (first),
      .data_i   (smp_data_i),
      .lo_nxt_o (lo_nxt),
      .hi_nxt_o (hi_nxt),
      .lo_q_o   (lo_q),
      .hi_q_o   (hi_q)
   );

   trim_accumulator #(.DATA_W(DATA_W), .ACC_W(ACC_W)) u_acc (
      .clk       (clk),
      .rst_n     (rst_n),
      .clear_i   (start_i),
      .accept_i  (accept),
      .data_i    (smp_data_i),
      .sum_nxt_o (sum_nxt)
   );

   trim_result_stage #(
      .DATA_W   (DATA_W),
      .ACC_W    (ACC_W),
      .SH_SHORT (SH_SHORT),
      .SH_LONG  (SH_LONG)
   ) u_res (
      .clk     (clk),
      .rst_n   (rst_n),
      .fire_i  (last),
      .len_i   (len_cur),
      .sum_i   (sum_nxt),
      .lo_i    (lo_nxt),
      .hi_i    (hi_nxt),
      .valid_o (res_valid_o),
      .data_o  (res_data_o)
   );

   generate
      if (PAD_W > 0) begin : g_pad
         assign res_word_o = {res_data_o, {PAD_W{1'b0}}};
      end else begin : g_nopad
         assign res_word_o = res_data_o;
      end
   endgenerate

   assert_valid_after_last_R1: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid_o |-> $past(last));

   assert_mean_in_span_R3: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid_o |-> (res_data_o >= lo_q && res_data_o <= hi_q));

endmodule

// File: tb/trim_mean_filter_tb_top.sv
module trim_mean_filter_tb_top;

   logic        clk = 1'b0;
   logic        rst_n, start, long_sel, smp_valid;
   logic [11:0] smp_data;
   logic        res_valid;
   logic [11:0] res_data;
   logic [15:0] res_word;

   always #4 clk = ~clk;

   trim_mean_filter dut_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .start_i     (start),
      .long_sel_i  (long_sel),
      .smp_valid_i (smp_valid),
      .smp_data_i  (smp_data),
      .res_valid_o (res_valid),
      .res_data_o  (res_data),
      .res_word_o  (res_word)
   );

   typedef struct {
      logic [11:0] val;
      string       tag;
   } exp_t;

   exp_t        sb_q[$];
   int          n_cmp = 0;
   int          n_bad = 0;
   logic [11:0] smp [0:15];
   logic        prev_vld = 1'b0;
   logic [31:0] seed = 32'h1234_5678;

   task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   // Monitor: pops the scoreboard at every result strobe
   always @(negedge clk) begin
      if (rst_n === 1'b1) begin
         if (res_valid === 1'b1) begin
            if (prev_vld) chk("R10 strobe longer than one cycle", 16'(res_valid), 16'h0);
            if (sb_q.size() == 0) begin
               n_cmp++;
               n_bad++;
               $display("FAIL R7 unexpected result act=%h exp=none", res_data);
            end else begin
               exp_t e;
               e = sb_q.pop_front();
               chk(e.tag, 16'(res_data), 16'(e.val));
               chk({e.tag, " R6 word"}, res_word, {e.val, 4'h0});
            end
         end
         prev_vld = (res_valid === 1'b1);
      end
   end

   function automatic logic [11:0] model(input bit sel);
      int tgt = sel ? 10 : 6;
      int sum = 0;
      int lo = 4095;
      int hi = 0;
      for (int i = 0; i < tgt; i++) begin
         sum += int'(smp[i]);
         if (int'(smp[i]) < lo) lo = int'(smp[i]);
         if (int'(smp[i]) > hi) hi = int'(smp[i]);
      end
      return 12'((sum - lo - hi) >> (sel ? 3 : 2));
   endfunction

   task automatic start_pulse(input bit sel);
      start = 1'b1;
      long_sel = sel;
      @(posedge clk); @(negedge clk);
      start = 1'b0;
      long_sel = ~sel;
   endtask

   task automatic send(input logic [11:0] d);
      smp_valid = 1'b1;
      smp_data = d;
      @(posedge clk); @(negedge clk);
      smp_valid = 1'b0;
   endtask

   task automatic burst(input bit sel, input int extra, input int gap, input string tag);
      int          tgt = sel ? 10 : 6;
      exp_t        e;
      logic [11:0] ev;
      ev = model(sel);
      e.val = ev;
      e.tag = tag;
      start_pulse(sel);
      sb_q.push_back(e);
      for (int i = 0; i < tgt; i++) begin
         send(smp[i]);
         if (i == tgt - 1) chk({tag, " timing R1 R2"}, 16'(res_valid), 16'h1);
         repeat (gap) @(negedge clk);
      end
      for (int k = 0; k < extra; k++) begin
         send(~smp[k]);
         chk("R7 no strobe on extra sample", 16'(res_valid), 16'h0);
      end
      if (extra > 0) chk("R7 result held", 16'(res_data), 16'(ev));
      repeat (2) @(negedge clk);
   endtask

   function automatic logic [11:0] rnd();
      seed ^= seed << 13;
      seed ^= seed >> 17;
      seed ^= seed << 5;
      return seed[11:0];
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog expired act=running exp=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      rst_n = 1'b0; start = 1'b0; long_sel = 1'b0; smp_valid = 1'b0; smp_data = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R9 reset valid", 16'(res_valid), 16'h0);
      chk("R9 reset data", 16'(res_data), 16'h0);
      chk("R9 reset word", res_word, 16'h0);
      // R9: strobes before the first start are ignored
      for (int i = 0; i < 12; i++) send(12'h3A0);
      chk("R9 ignored before start", 16'(res_data), 16'h0);

      // R1 R3: six distinct samples
      smp[0] = 12'd100; smp[1] = 12'd200; smp[2] = 12'd300;
      smp[3] = 12'd400; smp[4] = 12'd50;  smp[5] = 12'd900;
      burst(1'b0, 0, 0, "R1 R3 six distinct");

      // R2 R4: ten samples with a truncated remainder
      for (int i = 0; i < 10; i++) smp[i] = 12'(i * 37 + 11);
      smp[4] = 12'd3;
      burst(1'b1, 0, 0, "R2 R4 ten truncated");

      // R5: ties at both extremes
      smp[0] = 12'd5; smp[1] = 12'd5; smp[2] = 12'd100;
      smp[3] = 12'd100; smp[4] = 12'd9; smp[5] = 12'd40;
      burst(1'b0, 0, 0, "R5 ties six");
      for (int i = 0; i < 10; i++) smp[i] = 12'hFFF;
      smp[0] = 12'h000;
      burst(1'b1, 0, 0, "R5 R4 ten full scale");
      for (int i = 0; i < 6; i++) smp[i] = 12'h7;
      burst(1'b0, 0, 0, "R5 all equal");

      // R7: extra strobes after the burst
      for (int i = 0; i < 6; i++) smp[i] = 12'(600 + i * 13);
      burst(1'b0, 3, 0, "R7 burst with extras");

      // R8: restart mid-burst
      start_pulse(1'b1);
      send(12'hFFF); send(12'h000); send(12'hABC);
      for (int i = 0; i < 6; i++) smp[i] = 12'(1000 + i * 7);
      burst(1'b0, 0, 0, "R8 restart discards partial");

      // R1 R2: gaps between samples
      for (int i = 0; i < 10; i++) smp[i] = 12'(4000 - i * 301);
      burst(1'b1, 0, 2, "R2 gapped ten");

      // random bursts, alternating length
      for (int b = 0; b < 8; b++) begin
         for (int i = 0; i < 10; i++) smp[i] = rnd();
         burst(b[0], b % 3, b % 2, b[0] ? "R4 random ten" : "R3 random six");
      end

      chk("R1 scoreboard drained", 16'(sb_q.size()), 16'h0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule